// File: doc/BRIEF.md
# Stereo PCM Serial Output for an External DAC

The block turns a stream of 16-bit stereo sample pairs into the serial signals an external audio DAC expects. These are a gated copy of the over-sampling master clock, a bit clock divided down from it, a channel-select strobe, and a serial data line. The module is clocked by the master clock itself. That clock must already run at the selected multiple of the sample rate: 128, 256 or 384 times Fs.

Configuration inputs set four things: the over-sampling ratio, the number of bit-clock slots per channel (16 or 32), the channel-select level that marks the left channel, and a 5-bit start offset. The offset places the sample MSB inside each channel slot. An offset of 0 gives MSB-justified output, 1 gives I2S, and 16 with 32 slots gives LSB-justified output.

Samples arrive on a valid/ready stream into a one-pair holding buffer. Ready is high exactly when that buffer is empty. A pair is taken on any cycle where valid and ready are both high. Data and valid must stay steady while ready is low. The buffer is emptied into the serializer at the start of every left-channel slot, and that frees ready to request the next pair. If no pair is waiting at a frame start, that frame carries silence.

Top module: `adi_serializer`

## Requirements
- R1: With `ovs_sel` 01, 10 or 11 (128, 256 or 384 times Fs), `bclk_o` has a period of ratio/(2 × slots) master-clock cycles, where slots is 16 when `slot32`=0 and 32 when `slot32`=1. It is low for the first half of each period and high for the second half.
- R2: While `enable` is low, or while `ovs_sel` is 00, the outputs `mclk_o`, `bclk_o`, `ws_o` and `sdata_o` are all held low.
- R3: While the block is running, `mclk_o` follows the master clock `clk`.
- R4: `ws_o` changes only on a falling edge of `bclk_o` and toggles once per channel slot. During the left slot its level equals `ws_pol`; during the right slot it is the inverse.
- R5: `sdata_o` changes only on a falling edge of `bclk_o`. The sample is sent MSB first, so a DAC sampling on the rising edge sees stable data.
- R6: The sample MSB sits at slot position `just_ofs`, counted in bit clocks from the channel-select transition, which is position 0. Positions before the MSB and after the LSB are driven 0. A sample that extends past the end of the slot is cut off.
- R7: `s_ready` is high exactly when the holding buffer is empty. A transfer (`s_valid` and `s_ready` both high) makes `s_ready` low on the next cycle, and it stays low until the next frame start takes the pair.
- R8: At the start of each left slot, the waiting pair is latched for that frame. If no pair is waiting, both channels of that frame are sent as zeros.
- R9: After enabling, the first frame begins on the left channel at slot position 0, with all counters restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master (over-sampling) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the interface |
| ovs_sel | input | 2 | Over-sampling ratio code: 01=128, 10=256, 11=384, 00=reserved (idle) |
| slot32 | input | 1 | 0 = 16 slots per channel, 1 = 32 slots per channel |
| ws_pol | input | 1 | Level of `ws_o` during the left channel |
| just_ofs | input | 5 | Slot position of the sample MSB |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Holding buffer empty, pair accepted when valid |
| s_left | input | 16 | Left sample, two's complement |
| s_right | input | 16 | Right sample, two's complement |
| mclk_o | output | 1 | Gated master clock to the DAC |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Channel-select strobe |
| sdata_o | output | 1 | Serial data |

## Verification
The assertions check, on every cycle, the edge relationships: channel select and data change only on a falling bit clock, the phase counter stays inside the divide range, ready drops after a transfer, and a reserved code forces the serial outputs low. Some behaviours depend on configuration and data, and only the bench scenarios show them. These are the exact bit-clock period for each ratio and slot count, the slot position of each bit under MSB, I2S, LSB and arbitrary offsets, the left-channel level under both polarities, in-order delivery of pairs, silence on underrun, and a clean left-channel start after each enable.

// File: rtl/adi_pkg.sv
package adi_pkg;
  localparam int SAMPLE_W = 16;
  localparam int SAMPLE_IW = $clog2(SAMPLE_W);
  localparam int MAX_DIV = 12;
  localparam int DIV_W = $clog2(MAX_DIV + 1);
  localparam int JUST_W = 5;
  localparam int SLOT_W = 5;

  typedef enum logic [1:0] {
    OVS_RSVD = 2'b00,
    OVS_X128 = 2'b01,
    OVS_X256 = 2'b10,
    OVS_X384 = 2'b11
  } ovs_e;

  // Master-clock cycles per bit clock: ratio / (2 * slots)
  function automatic logic [DIV_W-1:0] bclk_div(input logic [1:0] ovs, input logic wide);
    logic [DIV_W-1:0] base;
    unique case (ovs_e'(ovs))
      OVS_X128: base = DIV_W'(4);
      OVS_X256: base = DIV_W'(8);
      OVS_X384: base = DIV_W'(12);
      default:  base = DIV_W'(4);
    endcase
    return wide ? (base >> 1) : base;
  endfunction
endpackage

// File: rtl/adi_bitclk.sv
module adi_bitclk
  import adi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIV_W-1:0]  div,
  input  logic              slot32,
  output logic              bclk,
  output logic [SLOT_W-1:0] bit_idx,
  output logic              chan,
  output logic              frame_end
);
  logic [DIV_W-1:0] pc;
  logic wrap_bit, last_bit;

  assign wrap_bit  = (pc == div - DIV_W'(1));
  assign last_bit  = (bit_idx == (slot32 ? SLOT_W'(31) : SLOT_W'(15)));
  assign frame_end = run && wrap_bit && last_bit && chan;
  assign bclk      = run && (pc >= (div >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      bit_idx <= '0;
      chan <= 1'b0;
    end else if (!run) begin
      pc <= '0;
      bit_idx <= '0;
      chan <= 1'b0;
    end else if (wrap_bit) begin
      pc <= '0;
      if (last_bit) begin
        bit_idx <= '0;
        chan <= ~chan;
      end else begin
        bit_idx <= bit_idx + SLOT_W'(1);
      end
    end else begin
      pc <= pc + DIV_W'(1);
    end
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pc < div)); // R1
endmodule

// File: rtl/adi_pairbuf.sv
module adi_pairbuf
  import adi_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic [SAMPLE_W-1:0] cur_l,
  output logic [SAMPLE_W-1:0] cur_r
);
  logic                pend_v;
  logic [SAMPLE_W-1:0] pend_l, pend_r;
  logic                accept;

  assign s_ready = ~pend_v;
  assign accept  = s_valid && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_l <= '0;
      pend_r <= '0;
      cur_l  <= '0;
      cur_r  <= '0;
    end else begin
      if (accept) begin
        pend_v <= 1'b1;
        pend_l <= s_left;
        pend_r <= s_right;
      end else if (load) begin
        pend_v <= 1'b0;
      end
      if (load) begin
        cur_l <= pend_v ? pend_l : '0;
        cur_r <= pend_v ? pend_r : '0;
      end
    end
  end

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready); // R7
endmodule

// File: rtl/adi_slotmux.sv
module adi_slotmux
  import adi_pkg::*;
(
  input  logic                run,
  input  logic                chan,
  input  logic [SLOT_W-1:0]   bit_idx,
  input  logic [JUST_W-1:0]   just,
  input  logic [SAMPLE_W-1:0] cur_l,
  input  logic [SAMPLE_W-1:0] cur_r,
  output logic                sdata
);
  localparam int REL_W = SLOT_W + 1;
  logic [REL_W-1:0]     rel;
  logic [SAMPLE_W-1:0]  sample;
  logic [SAMPLE_IW-1:0] pos;
  logic                 hit;

  always_comb begin
    sample = chan ? cur_r : cur_l;
    rel    = {1'b0, bit_idx} - REL_W'(just);
    hit    = run && ({1'b0, bit_idx} >= REL_W'(just)) && (rel < REL_W'(SAMPLE_W));
    pos    = SAMPLE_IW'(SAMPLE_W - 1) - rel[SAMPLE_IW-1:0];
    sdata  = hit ? sample[pos] : 1'b0;
  end
endmodule

// File: rtl/adi_serializer.sv
module adi_serializer
  import adi_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [1:0]          ovs_sel,
  input  logic                slot32,
  input  logic                ws_pol,
  input  logic [JUST_W-1:0]   just_ofs,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic                mclk_o,
  output logic                bclk_o,
  output logic                ws_o,
  output logic                sdata_o
);
  logic                en_req, en_q, load, frame_end, chan;
  logic [SLOT_W-1:0]   bit_idx;
  logic [SAMPLE_W-1:0] cur_l, cur_r;
  logic [DIV_W-1:0]    div;

  assign en_req = enable && (ovs_sel != OVS_RSVD);
  assign div    = bclk_div(ovs_sel, slot32);
  assign load   = (en_req && !en_q) || frame_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_req;
  end

  adi_bitclk u_bitclk (
    .clk(clk), .rst_n(rst_n), .run(en_q), .div(div), .slot32(slot32),
    .bclk(bclk_o), .bit_idx(bit_idx), .chan(chan), .frame_end(frame_end)
  );

  adi_pairbuf u_pairbuf (
    .clk(clk), .rst_n(rst_n), .load(load), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .cur_l(cur_l), .cur_r(cur_r)
  );

  adi_slotmux u_slotmux (
    .run(en_q), .chan(chan), .bit_idx(bit_idx), .just(just_ofs),
    .cur_l(cur_l), .cur_r(cur_r), .sdata(sdata_o)
  );

  assign mclk_o = clk & en_q;
  assign ws_o   = en_q & (chan ^ ws_pol);

  AST_WS_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q) && (ws_o != $past(ws_o))) |-> ($past(bclk_o) && !bclk_o)); // R4
  AST_DATA_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q) && (sdata_o != $past(sdata_o))) |-> ($past(bclk_o) && !bclk_o)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || ovs_sel == 2'b00) |=> (!bclk_o && !ws_o && !sdata_o)); // R2
endmodule

// File: tb/tb_adi_serializer.sv
module tb_adi_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  ovs_sel = 2'b01;
  logic        slot32 = 1'b0;
  logic        ws_pol = 1'b0;
  logic [4:0]  just_ofs = 5'd0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_left = '0, s_right = '0;
  logic        mclk_o, bclk_o, ws_o, sdata_o;

  int checks = 0, fails = 0;
  int exp_div = 4;
  logic [1:0] expq[$];

  always #5 clk = ~clk;

  adi_serializer dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ovs_sel(ovs_sel), .slot32(slot32),
    .ws_pol(ws_pol), .just_ofs(just_ofs), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .mclk_o(mclk_o), .bclk_o(bclk_o),
    .ws_o(ws_o), .sdata_o(sdata_o)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: compare each rising bit-clock sample against the scoreboard.
  logic prev_b = 1'b0;
  bit   armed = 1'b0;
  int   cnt = 0;
  always @(negedge clk) begin
    cnt++;
    if (bclk_o && !prev_b) begin
      if (armed) chk(cnt == exp_div, "R1 bclk period", cnt, exp_div);
      armed = 1'b1;
      cnt = 0;
      if (expq.size() > 0) begin
        logic [1:0] e;
        e = expq.pop_front();
        chk({ws_o, sdata_o} == e, "R4/R5/R6/R8/R9 ws,data", int'({ws_o, sdata_o}), int'(e));
      end
    end
    prev_b = bclk_o;
    if (!enable) armed = 1'b0;
  end

  task automatic push_frame(input logic [15:0] l, input logic [15:0] r);
    int slots;
    slots = slot32 ? 32 : 16;
    for (int ch = 0; ch < 2; ch++) begin
      for (int p = 0; p < slots; p++) begin
        logic [15:0] smp;
        logic b;
        smp = (ch == 0) ? l : r;
        b = (p >= just_ofs && p - just_ofs < 16) ? smp[15 - (p - just_ofs)] : 1'b0;
        expq.push_back({logic'(ch[0] ^ ws_pol), b});
      end
    end
  endtask

  task automatic send_pair(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_left = l; s_right = r; s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    chk(s_ready == 1'b0, "R7 ready low after transfer", s_ready, 0);
    push_frame(l, r);
  endtask

  task automatic run_cfg(input logic [1:0] o, input logic w, input logic pol,
                         input logic [4:0] j, input logic [15:0] seed);
    ovs_sel = o; slot32 = w; ws_pol = pol; just_ofs = j;
    exp_div = (128 * o) / (2 * (w ? 32 : 16));
    send_pair(seed, ~seed);
    enable = 1'b1;
    @(posedge clk); #2;
    chk(mclk_o == 1'b1, "R3 mclk high phase", mclk_o, 1);
    @(negedge clk);
    chk(mclk_o == 1'b0, "R3 mclk low phase", mclk_o, 0);
    send_pair(seed ^ 16'h5A3C, seed + 16'h1234);
    send_pair(16'h8001, 16'h7FFE);
    push_frame(16'h0000, 16'h0000);   // R8 underrun frame is silent
    while (expq.size() > 0) @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    chk({mclk_o, bclk_o, ws_o, sdata_o} == 4'b0, "R2 idle after disable",
        int'({mclk_o, bclk_o, ws_o, sdata_o}), 0);
  endtask

  initial begin
    #(1_000_000ns);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({bclk_o, ws_o, sdata_o, mclk_o} == 4'b0, "R2 reset idle", int'({bclk_o, ws_o, sdata_o}), 0);
    chk(s_ready == 1'b1, "R7 ready after reset", s_ready, 1);
    // R2 reserved ratio code keeps everything idle
    ovs_sel = 2'b00; enable = 1'b1; ws_pol = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #2;
      chk({mclk_o, bclk_o, ws_o, sdata_o} == 4'b0, "R2 reserved code idle",
          int'({mclk_o, bclk_o, ws_o, sdata_o}), 0);
    end
    enable = 1'b0;
    @(negedge clk);
    run_cfg(2'b01, 1'b0, 1'b0, 5'd0,  16'hA5C3);  // R6 MSB-justified, 128x
    run_cfg(2'b10, 1'b1, 1'b1, 5'd1,  16'h9E21);  // R6 I2S, 256x, R4 pol 1
    run_cfg(2'b11, 1'b0, 1'b0, 5'd0,  16'h4D7B);  // R1 divide-by-12
    run_cfg(2'b11, 1'b1, 1'b1, 5'd16, 16'hC0F5);  // R6 LSB-justified
    run_cfg(2'b01, 1'b1, 1'b0, 5'd3,  16'h3B96);  // R6 arbitrary offset, divide-by-2
    run_cfg(2'b10, 1'b0, 1'b1, 5'd16, 16'hFFFF);  // R6 offset past 16-slot end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule